// File: doc/BRIEF.md
# Line Sensor Readout Sequencer

This block is the control logic on the sensor side of a 102-pixel line imager. A command decoder ahead of it hands it one-cycle strobes for main reset, start of integration, sample, read, abort and two combined macros. From these it drives three controls for the pixel integrators: held in reset, integrating, and a latch pulse into the hold stage. It also keeps a flag that says whether the held samples are valid.

On a read it fetches each pixel value from the converter through a request/response port, one request per pixel, two clocks ahead of use. It sends the pixels as framed words on a serial output that changes on the falling clock edge. With each request it gives a zone index, so that the converter applies the gain and offset of the matching third of the array. Integration and readout run on separate state machines, so the next line can integrate while the current one is sent.

The integration state machine has three states. IG_RESET holds the integrators in reset. IG_PRESET runs the pixel reset cycle. IG_RUN is integration. Its transitions are:
- kill (main reset or abort) goes from any state to IG_RESET.
- start goes from any state to IG_PRESET.
- sample goes from any state to IG_RESET.
- preset done goes from IG_PRESET to IG_RUN.

The readout state machine has three states. RD_IDLE keeps the line high. RD_LEAD counts the fixed lead-in. RD_SEND shifts the frames out. Its transitions are:
- accept goes from RD_IDLE to RD_LEAD.
- lead done goes from RD_LEAD to RD_SEND.
- frame done, after the stop bit of the last pixel, goes from RD_SEND to RD_IDLE.
- kill goes from any state to RD_IDLE.

Top module: `line_readout_seq`

## Requirements
- R1: While `rst_n` is low: `sdout` and `int_rst` are 1, and `int_on`, `busy`, `held_valid`, `hold_pulse` and `pix_req` are 0.
- R2: A readout sends pixels 0 to 101 in ascending order. Each pixel is a 10-bit frame: a 0 start bit, then the 8 data bits least significant first, then one 1 stop bit. The next start bit follows the stop bit directly.
- R3: Call the rising edge that samples a read strobe edge 0. Edge 44 selects the first start bit, and `sdout` shows it from the falling edge that follows. Each later bit moves one clock per edge, always on a falling edge.
- R4: `busy` is 1 from edge 0 until the edge that would select the bit after the last stop bit. A read strobe that arrives while `busy` is 1 is ignored.
- R5: For each pixel, `pix_req` is high for one clock with `pix_idx` set to that pixel, and the indices arrive in ascending order. The converter must present the value on `pix_data` by the second rising edge after the edge that raised `pix_req`.
- R6: Whenever `pix_req` is high, `zone_sel` is 0 for index 0..33, 1 for 34..67 and 2 for 68..101.
- R7: A start strobe keeps `int_rst` at 1 through a 22-clock pixel reset cycle. `int_on` rises at the 22nd rising edge after the edge that sampled the strobe. A second start restarts the cycle.
- R8: A sample strobe makes `hold_pulse` 1 for exactly the next clock and sets `held_valid`. The integrators return to reset (`int_rst` 1, `int_on` 0).
- R9: An abort or main reset strobe has priority over every other strobe in the same cycle. From the next edge, `busy`, `held_valid` and `int_on` are 0 and `int_rst` is 1. `sdout` returns to 1 from the next falling edge.
- R10: The read-hold strobe acts as sample plus read. The read-hold-and-start strobe acts as sample plus read plus start. When sample and start fall in the same cycle, start decides the integrator state.
- R11: A start strobe during a readout does not disturb the serial stream, and integration begins on its normal schedule.
- R12: While no frame is being sent, `sdout` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all logic uses it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_reset | input | 1 | Main reset strobe |
| cmd_start | input | 1 | Start integration strobe |
| cmd_sample | input | 1 | Sample strobe |
| cmd_read | input | 1 | Read strobe |
| cmd_abort | input | 1 | Abort strobe |
| cmd_rdhold | input | 1 | Sample-and-read strobe |
| cmd_rdhold_start | input | 1 | Sample, read and start strobe |
| pix_data | input | 8 | Converted pixel value from the converter |
| int_rst | output | 1 | Integrators held in reset |
| int_on | output | 1 | Integration running |
| hold_pulse | output | 1 | One-clock latch into the hold stage |
| held_valid | output | 1 | Held samples are valid |
| pix_req | output | 1 | Pixel value request |
| pix_idx | output | 7 | Index of the requested pixel |
| zone_sel | output | 2 | Gain/offset zone of the requested pixel |
| busy | output | 1 | Readout in progress |
| sdout | output | 1 | Serial data out, changes on falling edge |

## Verification
The bench builds the block with its default parameters: 102 pixels, three zones of 34, a 44-clock lead-in and a 22-clock preset. Full frames are therefore short enough to run end to end. Each run reaches both zone boundaries, the last pixel's stop bit and the return to idle. The lead-in is short enough that an abort or main reset can be placed inside it as well as in the middle of a frame. Every frame uses a different pixel value pattern, so a bit-order or index slip shows up as a wrong bit.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
    typedef enum logic [1:0] {RD_IDLE, RD_LEAD, RD_SEND} rd_state_e;
    typedef enum logic [1:0] {IG_RESET, IG_PRESET, IG_RUN} ig_state_e;
endpackage

// File: rtl/lrs_integ_ctrl.sv
module lrs_integ_ctrl #(
    parameter int PRESET_CLKS = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kill,
    input  logic start_any,
    input  logic sample_any,
    output logic int_rst,
    output logic int_on,
    output logic hold_pulse,
    output logic held_valid
);
    import lrs_pkg::*;
    localparam int CW = $clog2(PRESET_CLKS + 1);

    ig_state_e state, nxt;
    logic [CW-1:0] cnt;

    always_comb begin
        nxt = state;
        if (kill)            nxt = IG_RESET;
        else if (start_any)  nxt = IG_PRESET;
        else if (sample_any) nxt = IG_RESET;
        else begin
            unique case (state)
                IG_PRESET: if (cnt == CW'(PRESET_CLKS - 1)) nxt = IG_RUN;
                default:   nxt = state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IG_RESET;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            hold_pulse <= 1'b0;
            held_valid <= 1'b0;
        end else begin
            hold_pulse <= sample_any && !kill;
            if (kill)            held_valid <= 1'b0;
            else if (sample_any) held_valid <= 1'b1;
            if (!kill && start_any)     cnt <= '0;
            else if (state == IG_PRESET) cnt <= cnt + 1'b1;
        end
    end

    assign int_on  = (state == IG_RUN);
    assign int_rst = !int_on;
endmodule

// File: rtl/lrs_zone_map.sv
module lrs_zone_map #(
    parameter int IDX_W     = 7,
    parameter int ZONE_PIX  = 34,
    parameter int NUM_ZONES = 3
) (
    input  logic [IDX_W-1:0]             idx,
    output logic [$clog2(NUM_ZONES)-1:0] zone
);
    localparam int ZW = $clog2(NUM_ZONES);

    logic [NUM_ZONES-1:1] past;

    for (genvar z = 1; z < NUM_ZONES; z++) begin : g_edge
        assign past[z] = (int'(idx) >= z * ZONE_PIX);
    end

    always_comb begin
        zone = '0;
        for (int k = 1; k < NUM_ZONES; k++)
            if (past[k]) zone = ZW'(k);
    end
endmodule

// File: rtl/lrs_readout_fsm.sv
module lrs_readout_fsm #(
    parameter int NUM_PIX   = 102,
    parameter int WORD_W    = 8,
    parameter int LEAD_CLKS = 44
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       kill,
    input  logic                       read_any,
    input  logic [WORD_W-1:0]          pix_data,
    output logic                       pix_req,
    output logic [$clog2(NUM_PIX)-1:0] pix_idx,
    output logic                       busy,
    output logic                       sdout
);
    import lrs_pkg::*;
    localparam int IDX_W    = $clog2(NUM_PIX);
    localparam int LW       = $clog2(LEAD_CLKS);
    localparam int BW       = $clog2(WORD_W + 2);
    localparam int LAST_POS = WORD_W + 1;
    localparam int LAST_IDX = NUM_PIX - 1;
    localparam int REQ_AT   = LEAD_CLKS - 5;

    rd_state_e        state, nxt;
    logic [LW-1:0]    lead_cnt;
    logic [BW-1:0]    bit_pos;
    logic [IDX_W-1:0] pix_cnt;
    logic [WORD_W-1:0] shreg, nxt_word;
    logic             req_d, tx_bit;

    always_comb begin
        nxt = state;
        unique case (state)
            RD_IDLE: if (read_any) nxt = RD_LEAD;
            RD_LEAD: if (lead_cnt == LW'(LEAD_CLKS - 1)) nxt = RD_SEND;
            RD_SEND: if (bit_pos == BW'(LAST_POS) && pix_cnt == IDX_W'(LAST_IDX)) nxt = RD_IDLE;
            default: nxt = RD_IDLE;
        endcase
        if (kill) nxt = RD_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RD_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lead_cnt <= '0;
            bit_pos  <= '0;
            pix_cnt  <= '0;
            shreg    <= '0;
            nxt_word <= '0;
            req_d    <= 1'b0;
            tx_bit   <= 1'b1;
            pix_req  <= 1'b0;
            pix_idx  <= '0;
        end else begin
            pix_req <= 1'b0;
            req_d   <= pix_req;
            if (req_d) nxt_word <= pix_data;
            if (kill) begin
                tx_bit <= 1'b1;
                req_d  <= 1'b0;
            end else begin
                unique case (state)
                    RD_IDLE: begin
                        tx_bit   <= 1'b1;
                        lead_cnt <= '0;
                    end
                    RD_LEAD: begin
                        lead_cnt <= lead_cnt + 1'b1;
                        if (lead_cnt == LW'(REQ_AT)) begin
                            pix_req <= 1'b1;
                            pix_idx <= '0;
                        end
                        if (lead_cnt == LW'(LEAD_CLKS - 1)) begin
                            tx_bit  <= 1'b0;
                            bit_pos <= '0;
                            pix_cnt <= '0;
                            shreg   <= nxt_word;
                        end
                    end
                    RD_SEND: begin
                        if (bit_pos < BW'(WORD_W)) begin
                            tx_bit  <= shreg[0];
                            shreg   <= shreg >> 1;
                            bit_pos <= bit_pos + 1'b1;
                            if (bit_pos == BW'(1) && pix_cnt != IDX_W'(LAST_IDX)) begin
                                pix_req <= 1'b1;
                                pix_idx <= pix_cnt + 1'b1;
                            end
                        end else if (bit_pos == BW'(WORD_W)) begin
                            tx_bit  <= 1'b1;
                            bit_pos <= bit_pos + 1'b1;
                        end else if (pix_cnt == IDX_W'(LAST_IDX)) begin
                            tx_bit <= 1'b1;
                        end else begin
                            tx_bit  <= 1'b0;
                            bit_pos <= '0;
                            pix_cnt <= pix_cnt + 1'b1;
                            shreg   <= nxt_word;
                        end
                    end
                    default: tx_bit <= 1'b1;
                endcase
            end
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) sdout <= 1'b1;
        else        sdout <= tx_bit;
    end

    assign busy = (state != RD_IDLE);
endmodule

// File: rtl/line_readout_seq.sv
module line_readout_seq #(
    parameter int NUM_PIX     = 102,
    parameter int ZONE_PIX    = 34,
    parameter int NUM_ZONES   = 3,
    parameter int WORD_W      = 8,
    parameter int LEAD_CLKS   = 44,
    parameter int PRESET_CLKS = 22
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_reset,
    input  logic                         cmd_start,
    input  logic                         cmd_sample,
    input  logic                         cmd_read,
    input  logic                         cmd_abort,
    input  logic                         cmd_rdhold,
    input  logic                         cmd_rdhold_start,
    input  logic [WORD_W-1:0]            pix_data,
    output logic                         int_rst,
    output logic                         int_on,
    output logic                         hold_pulse,
    output logic                         held_valid,
    output logic                         pix_req,
    output logic [$clog2(NUM_PIX)-1:0]   pix_idx,
    output logic [$clog2(NUM_ZONES)-1:0] zone_sel,
    output logic                         busy,
    output logic                         sdout
);
    localparam int IDX_W = $clog2(NUM_PIX);

    logic kill, start_any, sample_any, read_any;

    assign kill       = cmd_reset | cmd_abort;
    assign start_any  = cmd_start | cmd_rdhold_start;
    assign sample_any = cmd_sample | cmd_rdhold | cmd_rdhold_start;
    assign read_any   = cmd_read | cmd_rdhold | cmd_rdhold_start;

    lrs_integ_ctrl #(.PRESET_CLKS(PRESET_CLKS)) u_integ (
        .clk(clk), .rst_n(rst_n), .kill(kill), .start_any(start_any),
        .sample_any(sample_any), .int_rst(int_rst), .int_on(int_on),
        .hold_pulse(hold_pulse), .held_valid(held_valid)
    );

    lrs_readout_fsm #(.NUM_PIX(NUM_PIX), .WORD_W(WORD_W), .LEAD_CLKS(LEAD_CLKS)) u_rd (
        .clk(clk), .rst_n(rst_n), .kill(kill), .read_any(read_any),
        .pix_data(pix_data), .pix_req(pix_req), .pix_idx(pix_idx),
        .busy(busy), .sdout(sdout)
    );

    lrs_zone_map #(.IDX_W(IDX_W), .ZONE_PIX(ZONE_PIX), .NUM_ZONES(NUM_ZONES)) u_zone (
        .idx(pix_idx), .zone(zone_sel)
    );
endmodule

// File: rtl/lrs_checker.sv
module lrs_checker #(
    parameter int NUM_PIX     = 102,
    parameter int ZONE_PIX    = 34,
    parameter int NUM_ZONES   = 3,
    parameter int PRESET_CLKS = 22
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cmd_reset,
    input logic                         cmd_start,
    input logic                         cmd_sample,
    input logic                         cmd_read,
    input logic                         cmd_abort,
    input logic                         cmd_rdhold,
    input logic                         cmd_rdhold_start,
    input logic                         int_rst,
    input logic                         int_on,
    input logic                         hold_pulse,
    input logic                         held_valid,
    input logic                         pix_req,
    input logic [$clog2(NUM_PIX)-1:0]   pix_idx,
    input logic [$clog2(NUM_ZONES)-1:0] zone_sel,
    input logic                         busy,
    input logic                         sdout
);
    localparam int ZW = $clog2(NUM_ZONES);

    logic       kill_c;
    logic [7:0] since_start;

    assign kill_c = cmd_reset || cmd_abort;

    // Clocks since the last accepted start strobe, saturating.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_start <= 8'hFF;
        else if ((cmd_start || cmd_rdhold_start) && !kill_c) since_start <= 8'h00;
        else if (since_start != 8'hFF) since_start <= since_start + 8'h01;
    end

    // R4
    p_busy_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_read && !busy && !kill_c) |=> busy);

    // R6
    p_zone_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |-> (zone_sel == ZW'(int'(pix_idx) / ZONE_PIX)));

    // R7
    p_preset_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_on) |-> (since_start == 8'(PRESET_CLKS)));

    // R8
    p_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_sample && !kill_c && !cmd_start && !cmd_rdhold_start)
        |=> (hold_pulse && held_valid && int_rst && !int_on));

    // R9
    p_kill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        kill_c |=> (!busy && !held_valid && int_rst && !int_on && !hold_pulse));

    // R12
    p_idle_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> sdout);
endmodule

bind line_readout_seq lrs_checker #(
    .NUM_PIX(NUM_PIX), .ZONE_PIX(ZONE_PIX), .NUM_ZONES(NUM_ZONES), .PRESET_CLKS(PRESET_CLKS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .cmd_start(cmd_start),
    .cmd_sample(cmd_sample), .cmd_read(cmd_read), .cmd_abort(cmd_abort),
    .cmd_rdhold(cmd_rdhold), .cmd_rdhold_start(cmd_rdhold_start),
    .int_rst(int_rst), .int_on(int_on), .hold_pulse(hold_pulse),
    .held_valid(held_valid), .pix_req(pix_req), .pix_idx(pix_idx),
    .zone_sel(zone_sel), .busy(busy), .sdout(sdout)
);

// File: tb/tb_line_readout_seq.sv
module tb_line_readout_seq;
    localparam int NPIX = 102, ZPIX = 34, NZ = 3, WW = 8, LEAD = 44, PRE = 22;
    localparam int FBITS = NPIX * (WW + 2);
    localparam int LAST_BUSY = LEAD + FBITS - 1;
    localparam int INF = 1 << 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [6:0] cmds = '0;   // 0 reset,1 start,2 sample,3 read,4 abort,5 rdhold,6 rdhold_start
    logic [7:0] pix_data = '0;
    logic int_rst, int_on, hold_pulse, held_valid, pix_req, busy, sdout;
    logic [6:0] pix_idx;
    logic [1:0] zone_sel;
    int seed = 0;
    int total = 0, bad = 0;

    localparam logic [6:0] C_RST = 7'h01, C_START = 7'h02, C_SAMP = 7'h04, C_READ = 7'h08,
                           C_ABORT = 7'h10, C_RH = 7'h20, C_RHS = 7'h40;

    always #2 clk = ~clk;

    line_readout_seq #(.NUM_PIX(NPIX), .ZONE_PIX(ZPIX), .NUM_ZONES(NZ), .WORD_W(WW),
                       .LEAD_CLKS(LEAD), .PRESET_CLKS(PRE)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_reset(cmds[0]), .cmd_start(cmds[1]),
        .cmd_sample(cmds[2]), .cmd_read(cmds[3]), .cmd_abort(cmds[4]),
        .cmd_rdhold(cmds[5]), .cmd_rdhold_start(cmds[6]), .pix_data(pix_data),
        .int_rst(int_rst), .int_on(int_on), .hold_pulse(hold_pulse),
        .held_valid(held_valid), .pix_req(pix_req), .pix_idx(pix_idx),
        .zone_sel(zone_sel), .busy(busy), .sdout(sdout)
    );

    function automatic logic [7:0] conv(int idx, int s);
        return 8'((idx * 37 + s * 13 + (idx >> 2)) & 255);
    endfunction

    function automatic int frame_bit(int j, int s);
        int p = j / (WW + 2);
        int b = j % (WW + 2);
        logic [7:0] w = conv(p, s);
        if (b == 0) return 0;
        if (b == WW + 1) return 1;
        return int'(w[b-1]);
    endfunction

    // converter stand-in: value ready one edge after the request is seen
    always @(posedge clk) if (pix_req) pix_data <= conv(int'(pix_idx), seed);

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic pulse(logic [6:0] m);
        @(negedge clk); cmds = m;
        @(negedge clk); cmds = '0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // cycle-by-cycle reference model
    int cyc = 0, rd_p0 = -100000, rd_a = INF, s_at = 0, req_cnt = 0, seedm = 0;
    bit busy_prev = 0, preset_mode = 0, held_m = 0, hold_m = 0;

    initial begin
        forever begin
            @(posedge clk); #1;
            if (rst_n) begin
                bit kill, samp, strt, rd, busy_now, on_m;
                int m, j, exp_sd;
                cyc++;
                kill = cmds[0] || cmds[4];
                samp = cmds[2] || cmds[5] || cmds[6];
                strt = cmds[1] || cmds[6];
                rd   = cmds[3] || cmds[5] || cmds[6];
                if (kill) begin
                    if (busy_prev) rd_a = cyc;
                    preset_mode = 0; held_m = 0; hold_m = 0;
                end else begin
                    hold_m = samp;
                    if (samp) begin held_m = 1; preset_mode = 0; end
                    if (strt) begin preset_mode = 1; s_at = cyc; end
                    if (rd && !busy_prev) begin
                        rd_p0 = cyc; rd_a = INF; seedm = seed; req_cnt = 0;
                    end
                end
                busy_now = (cyc >= rd_p0) && (cyc <= rd_p0 + LAST_BUSY) && (cyc < rd_a);
                on_m = preset_mode && (cyc - s_at >= PRE);
                m = cyc - 1;
                j = m - rd_p0 - LEAD;
                if (j >= 0 && j < FBITS && m < rd_a) begin
                    exp_sd = frame_bit(j, seedm);
                    chk("R2 R3 sdout frame bit", int'(sdout), exp_sd);
                end else
                    chk("R12 sdout idle", int'(sdout), 1);
                chk("R4 busy", int'(busy), int'(busy_now));
                chk("R7 int_on", int'(int_on), int'(on_m));
                chk("R7 int_rst", int'(int_rst), int'(!on_m));
                chk("R8 R9 held_valid", int'(held_valid), int'(held_m));
                chk("R8 hold_pulse", int'(hold_pulse), int'(hold_m));
                if (pix_req) begin
                    chk("R5 pix_idx order", int'(pix_idx), req_cnt);
                    chk("R6 zone_sel", int'(zone_sel), int'(pix_idx) / ZPIX);
                    req_cnt++;
                end
                busy_prev = busy_now;
            end
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 sdout", int'(sdout), 1);
        chk("R1 busy", int'(busy), 0);
        chk("R1 int_rst", int'(int_rst), 1);
        chk("R1 int_on", int'(int_on), 0);
        chk("R1 held_valid", int'(held_valid), 0);
        chk("R1 hold_pulse", int'(hold_pulse), 0);
        chk("R1 pix_req", int'(pix_req), 0);
        @(negedge clk); rst_n = 1'b1;
        wait_cyc(5);

        // R7 start, then R8 sample, then a full read
        pulse(C_START); wait_cyc(30);
        pulse(C_SAMP);  wait_cyc(3);
        seed = 11;
        pulse(C_READ);  wait_cyc(300);
        pulse(C_START); wait_cyc(200);      // R11 start during readout
        pulse(C_READ);                      // R4 ignored while busy
        wait_cyc(650);
        chk("R11 int_on after start during readout", int'(int_on), 1);
        wait_cyc(20);                       // R12 idle line

        // R10 sample + read + start macro
        seed = 200;
        pulse(C_RHS);
        chk("R10 busy after macro", int'(busy), 1);
        chk("R10 held_valid after macro", int'(held_valid), 1);
        wait_cyc(1100);

        // R9 abort mid-frame after sample + read macro
        seed = 77;
        pulse(C_RH); wait_cyc(500);
        pulse(C_ABORT);
        chk("R9 busy after abort", int'(busy), 0);
        wait_cyc(10);

        // R9 main reset during lead-in
        seed = 5;
        pulse(C_READ); wait_cyc(20);
        pulse(C_RST);  wait_cyc(5);

        // R9 reset wins over read in the same cycle
        pulse(C_READ | C_RST);
        chk("R9 read blocked by reset", int'(busy), 0);
        wait_cyc(5);

        // final frame read while integrating, with a fresh pattern
        seed = 123;
        pulse(C_START); wait_cyc(25);
        pulse(C_RH);    wait_cyc(1100);
        finish_run();
    end
endmodule